// File: doc/BRIEF.md
# Instruction Fetch with Load-Use Interlock

This block is the front of a five-stage scalar pipeline. A word-aligned program counter walks a 4 KB instruction space, one word per cycle, and addresses the instruction memory through an asynchronous read port. The read port sits at a fixed base offset inside a larger local memory. Each fetched word is captured together with its program counter, its pre-decoded opcode and three decode flags (is-load, uses-rs, uses-rt) in a fetch/decode register. On the next cycle that register is copied into a decode/execute register that feeds the execute stage.

Between the two registers an interlock compares the instruction leaving decode with the load now in execute. The downstream logic reports the load's destination register on `ld_dest`. When the instruction in the decode/execute register is a load, the reported destination is not register zero, and the instruction in decode really reads that register as rs or as rt, the interlock raises `stall`. In that cycle the decode/execute register takes a bubble: an all-zero instruction word with the no-op opcode and cleared flags. The program counter and the fetch/decode register hold, so the same instruction is offered again on the next cycle.

Top module: `fe_fetch_interlock`

## Requirements
- R1: While reset is high at a clock edge, the program counter becomes 0, so `imem_addr` shows the base 0x1000. Both pipeline registers take the no-op form: word 0, opcode 0, all flags 0. `stall` is low after reset.
- R2: `imem_addr` equals 0x1000 plus the program counter. In every cycle without a stall the program counter grows by 4, and it wraps from 0xFFC to 0.
- R3: The word, opcode and flags read at address 0x1000+P are latched with P. Two non-stalled edges later they appear on `de_word`, `de_opc`, `de_is_load`/`de_use_rs`/`de_use_rt` and `de_pc`.
- R4: `stall` stays low whenever `de_is_load` is low, whatever `ld_dest` holds.
- R5: `stall` is high when `de_is_load` is high, `ld_dest` is nonzero, and `ld_dest` equals bits [25:21] (rs) of the instruction in decode while that instruction has its uses-rs flag set.
- R6: `stall` is high when `ld_dest` (nonzero, with a load in execute) equals bits [20:16] (rt) of the decode instruction while it uses rt. A match on a field whose use flag is clear causes no stall.
- R7: A load whose destination is register 0 never causes a stall.
- R8: At the edge after a stall, the decode/execute register holds word 0x00000000, opcode 0 (the shift-left-logical no-op), all flags 0, and the program counter of the held instruction.
- R9: During a stall cycle the program counter and the fetch/decode register hold. At the following edge the held instruction enters the decode/execute register.
- R10: A stall lasts exactly one cycle, because the bubble carries no load flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 13 | Byte address of the instruction memory read port (base + PC) |
| imem_word | input | 32 | Instruction word at `imem_addr`, same cycle |
| imem_opc | input | 6 | Pre-decoded opcode of that word |
| imem_is_load | input | 1 | The word is a load |
| imem_use_rs | input | 1 | The word reads its rs field |
| imem_use_rt | input | 1 | The word reads its rt field |
| ld_dest | input | 5 | Destination register of the instruction now in execute |
| de_pc | output | 12 | Decode/execute register: program counter |
| de_word | output | 32 | Decode/execute register: instruction word |
| de_opc | output | 6 | Decode/execute register: opcode |
| de_is_load | output | 1 | Decode/execute register: is-load flag |
| de_use_rs | output | 1 | Decode/execute register: uses-rs flag |
| de_use_rt | output | 1 | Decode/execute register: uses-rt flag |
| stall | output | 1 | Interlock fired: bubble into execute, fetch frozen |

## Verification
The bench builds the block with its default parameters. These give a 4 KB space at base 0x1000, 5-bit register fields at bits 25:21 and 20:16, and register zero hard-wired. The 1024-word space lets a run of pure fetch reach the 0xFFC-to-0 wrap within about a thousand cycles. The hard-wired zero option puts the register-zero exemption in reach next to the rs, rt, unused-operand and non-load cases. The bench models the execute stage by reporting the rt field of a load in the decode/execute register as `ld_dest`. It can also force `ld_dest` to show that a non-load never stalls.

// File: rtl/fe_pkg.sv
package fe_pkg;

   typedef struct packed {
      logic is_load;
      logic use_rs;
      logic use_rt;
   } insn_flags_t;

   localparam insn_flags_t FLAGS_NONE = '{is_load: 1'b0, use_rs: 1'b0, use_rt: 1'b0};

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/fe_pc_gen.sv
module fe_pc_gen #(
   parameter int unsigned PC_W      = 12,
   parameter int unsigned ADDR_W    = 13,
   parameter int unsigned IMEM_BASE = 32'h1000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hold,
   output logic [PC_W-1:0]   pc_o,
   output logic [ADDR_W-1:0] addr_o
);
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(IMEM_BASE);
   localparam logic [PC_W-1:0]   STEP = PC_W'(4);

   logic [PC_W-1:0] pc_q;

   always_ff @(posedge clk) begin
      if (rst)        pc_q <= '0;
      else if (!hold) pc_q <= pc_q + STEP;
   end

   assign pc_o   = pc_q;
   assign addr_o = BASE + ADDR_W'(pc_q);

   // R2: free-running advance by one word, wrapping inside the space
   p_pc_advance_r2: assert property (@(posedge clk) disable iff (rst)
      !hold |=> pc_q == $past(pc_q) + STEP);

   // R9: a stall freezes the fetch address
   p_pc_hold_r9: assert property (@(posedge clk) disable iff (rst)
      hold |=> pc_q == $past(pc_q));

   // R2: word alignment is kept
   p_pc_aligned_r2: assert property (@(posedge clk) disable iff (rst)
      pc_q[1:0] == 2'b00);

endmodule

// File: rtl/fe_pipe_reg.sv
module fe_pipe_reg
   import fe_pkg::*;
#(
   parameter int unsigned PC_W    = 12,
   parameter int unsigned IW_W    = 32,
   parameter int unsigned OPC_W   = 6,
   parameter int unsigned NOP_OPC = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              kill,
   input  logic [PC_W-1:0]   d_pc,
   input  logic [IW_W-1:0]   d_word,
   input  logic [OPC_W-1:0]  d_opc,
   input  insn_flags_t       d_flags,
   output logic [PC_W-1:0]   q_pc,
   output logic [IW_W-1:0]   q_word,
   output logic [OPC_W-1:0]  q_opc,
   output insn_flags_t       q_flags
);
   localparam logic [OPC_W-1:0] NOP = OPC_W'(NOP_OPC);

   always_ff @(posedge clk) begin
      if (rst) begin
         q_pc    <= '0;
         q_word  <= '0;
         q_opc   <= NOP;
         q_flags <= FLAGS_NONE;
      end else if (kill) begin
         q_pc    <= d_pc;
         q_word  <= '0;
         q_opc   <= NOP;
         q_flags <= FLAGS_NONE;
      end else if (en) begin
         q_pc    <= d_pc;
         q_word  <= d_word;
         q_opc   <= d_opc;
         q_flags <= d_flags;
      end
   end

   // R9: a disabled, unkilled register keeps its contents
   p_reg_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (!en && !kill) |=> ($stable(q_word) && $stable(q_pc) && $stable(q_flags)));

endmodule

// File: rtl/fe_hazard_detect.sv
module fe_hazard_detect #(
   parameter int unsigned REG_W          = 5,
   parameter bit          ZERO_HARDWIRED = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             prev_is_load,
   input  logic [REG_W-1:0] ld_dest,
   input  logic [REG_W-1:0] src_rs,
   input  logic [REG_W-1:0] src_rt,
   input  logic             use_rs,
   input  logic             use_rt,
   output logic             stall
);
   logic [REG_W-1:0] src [2];
   logic [1:0]       use_v;
   logic [1:0]       hit;
   logic             dest_live;

   assign src[0] = src_rs;
   assign src[1] = src_rt;
   assign use_v  = {use_rt, use_rs};

   for (genvar i = 0; i < 2; i++) begin : g_opnd
      assign hit[i] = use_v[i] && (src[i] == ld_dest);
   end

   if (ZERO_HARDWIRED) begin : g_zero_fixed
      assign dest_live = |ld_dest;
      // R7: register zero never triggers the interlock
      p_zero_never_stalls_r7: assert property (@(posedge clk) disable iff (rst)
         (ld_dest == '0) |-> !stall);
   end else begin : g_zero_plain
      assign dest_live = 1'b1;
   end

   assign stall = prev_is_load && dest_live && (|hit);

   // R4: only a load in execute can stall
   p_needs_load_r4: assert property (@(posedge clk) disable iff (rst)
      !prev_is_load |-> !stall);

   // R6: an operand that is not read never causes a stall
   p_unused_operands_r6: assert property (@(posedge clk) disable iff (rst)
      (!use_rs && !use_rt) |-> !stall);

endmodule

// File: rtl/fe_fetch_interlock.sv
module fe_fetch_interlock
   import fe_pkg::*;
#(
   parameter int unsigned IMEM_BYTES     = 4096,
   parameter int unsigned IMEM_BASE      = 32'h1000,
   parameter int unsigned ADDR_W         = 13,
   parameter int unsigned IW_W           = 32,
   parameter int unsigned OPC_W          = 6,
   parameter int unsigned NOP_OPC        = 0,
   parameter int unsigned REG_W          = 5,
   parameter int unsigned RS_LSB         = 21,
   parameter int unsigned RT_LSB         = 16,
   parameter bit          ZERO_HARDWIRED = 1'b1,
   localparam int unsigned PC_W          = $clog2(IMEM_BYTES)
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] imem_addr,
   input  logic [IW_W-1:0]   imem_word,
   input  logic [OPC_W-1:0]  imem_opc,
   input  logic              imem_is_load,
   input  logic              imem_use_rs,
   input  logic              imem_use_rt,
   input  logic [REG_W-1:0]  ld_dest,
   output logic [PC_W-1:0]   de_pc,
   output logic [IW_W-1:0]   de_word,
   output logic [OPC_W-1:0]  de_opc,
   output logic              de_is_load,
   output logic              de_use_rs,
   output logic              de_use_rt,
   output logic              stall
);
   // elaboration-time parameter checks
   if (!is_pow2(IMEM_BYTES) || IMEM_BYTES < 8) begin : g_bad_size
      $error("IMEM_BYTES must be a power of two of at least 8");
   end
   if ((IMEM_BASE % IMEM_BYTES) != 0) begin : g_bad_base
      $error("IMEM_BASE must be aligned to IMEM_BYTES");
   end
   if (longint'(IMEM_BASE) + longint'(IMEM_BYTES) > (longint'(1) << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for IMEM_BASE + IMEM_BYTES");
   end
   if (RS_LSB + REG_W > IW_W || RT_LSB + REG_W > IW_W) begin : g_bad_fields
      $error("register fields exceed the instruction word");
   end

   localparam logic [OPC_W-1:0] NOP = OPC_W'(NOP_OPC);

   logic [PC_W-1:0]  pc;
   insn_flags_t      in_flags;
   logic [PC_W-1:0]  fd_pc;
   logic [IW_W-1:0]  fd_word;
   logic [OPC_W-1:0] fd_opc;
   insn_flags_t      fd_flags;
   insn_flags_t      de_flags;

   assign in_flags = '{is_load: imem_is_load, use_rs: imem_use_rs, use_rt: imem_use_rt};

   fe_pc_gen #(
      .PC_W      (PC_W),
      .ADDR_W    (ADDR_W),
      .IMEM_BASE (IMEM_BASE)
   ) u_pc (
      .clk    (clk),
      .rst    (rst),
      .hold   (stall),
      .pc_o   (pc),
      .addr_o (imem_addr)
   );

   fe_pipe_reg #(
      .PC_W (PC_W), .IW_W (IW_W), .OPC_W (OPC_W), .NOP_OPC (NOP_OPC)
   ) u_fd (
      .clk     (clk),
      .rst     (rst),
      .en      (!stall),
      .kill    (1'b0),
      .d_pc    (pc),
      .d_word  (imem_word),
      .d_opc   (imem_opc),
      .d_flags (in_flags),
      .q_pc    (fd_pc),
      .q_word  (fd_word),
      .q_opc   (fd_opc),
      .q_flags (fd_flags)
   );

   fe_hazard_detect #(
      .REG_W          (REG_W),
      .ZERO_HARDWIRED (ZERO_HARDWIRED)
   ) u_hz (
      .clk          (clk),
      .rst          (rst),
      .prev_is_load (de_flags.is_load),
      .ld_dest      (ld_dest),
      .src_rs       (fd_word[RS_LSB +: REG_W]),
      .src_rt       (fd_word[RT_LSB +: REG_W]),
      .use_rs       (fd_flags.use_rs),
      .use_rt       (fd_flags.use_rt),
      .stall        (stall)
   );

   fe_pipe_reg #(
      .PC_W (PC_W), .IW_W (IW_W), .OPC_W (OPC_W), .NOP_OPC (NOP_OPC)
   ) u_de (
      .clk     (clk),
      .rst     (rst),
      .en      (1'b1),
      .kill    (stall),
      .d_pc    (fd_pc),
      .d_word  (fd_word),
      .d_opc   (fd_opc),
      .d_flags (fd_flags),
      .q_pc    (de_pc),
      .q_word  (de_word),
      .q_opc   (de_opc),
      .q_flags (de_flags)
   );

   assign de_is_load = de_flags.is_load;
   assign de_use_rs  = de_flags.use_rs;
   assign de_use_rt  = de_flags.use_rt;

   // R8: the cycle after a stall shows the no-op bubble in execute
   p_bubble_shape_r8: assert property (@(posedge clk) disable iff (rst)
      stall |=> (de_word == '0 && de_opc == NOP && !de_is_load && !de_use_rs && !de_use_rt));

   // R8: the bubble carries the program counter of the held instruction
   p_bubble_pc_r8: assert property (@(posedge clk) disable iff (rst)
      stall |=> de_pc == $past(fd_pc));

   // R10: never two stall cycles in a row
   p_single_stall_r10: assert property (@(posedge clk) disable iff (rst)
      stall |=> !stall);

   // R3: without a stall the decode instruction moves into execute unchanged
   p_forward_r3: assert property (@(posedge clk) disable iff (rst)
      !stall |=> (de_word == $past(fd_word) && de_pc == $past(fd_pc)));

endmodule

// File: tb/fe_fetch_interlock_bench.sv
module fe_fetch_interlock_bench;

   localparam int unsigned BASE  = 32'h1000;
   localparam int unsigned WORDS = 1024;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [12:0] imem_addr;
   logic [31:0] imem_word;
   logic [5:0]  imem_opc;
   logic        imem_is_load, imem_use_rs, imem_use_rt;
   logic [4:0]  ld_dest;
   logic [11:0] de_pc;
   logic [31:0] de_word;
   logic [5:0]  de_opc;
   logic        de_is_load, de_use_rs, de_use_rt;
   logic        stall;

   logic [31:0] prog_w   [WORDS];
   logic [5:0]  prog_o   [WORDS];
   logic [2:0]  prog_f   [WORDS];   // {use_rt, use_rs, is_load}
   logic        force_en  = 1'b0;
   logic [4:0]  force_val = '0;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   assign imem_word    = prog_w[imem_addr[11:2]];
   assign imem_opc     = prog_o[imem_addr[11:2]];
   assign imem_is_load = prog_f[imem_addr[11:2]][0];
   assign imem_use_rs  = prog_f[imem_addr[11:2]][1];
   assign imem_use_rt  = prog_f[imem_addr[11:2]][2];
   // execute-stage model: a load writes its rt field
   assign ld_dest = force_en ? force_val : (de_is_load ? de_word[20:16] : 5'd0);

   fe_fetch_interlock u_fe_fetch_interlock (
      .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_word(imem_word),
      .imem_opc(imem_opc), .imem_is_load(imem_is_load), .imem_use_rs(imem_use_rs),
      .imem_use_rt(imem_use_rt), .ld_dest(ld_dest), .de_pc(de_pc), .de_word(de_word),
      .de_opc(de_opc), .de_is_load(de_is_load), .de_use_rs(de_use_rs),
      .de_use_rt(de_use_rt), .stall(stall)
   );

   function automatic logic [31:0] mkw(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt);
      return {op, rs, rt, 16'h0C35};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_prog();
      for (int i = 0; i < WORDS; i++) begin
         prog_w[i] = '0; prog_o[i] = '0; prog_f[i] = '0;
      end
      force_en = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk) rst = 1'b1;
      @(negedge clk) rst = 1'b0;
   endtask

   // load with destination d at word 0, then instruction w1 with flags f1 at word 1
   task automatic load_pair(input logic [4:0] d, input logic [31:0] w1, input logic [2:0] f1);
      clear_prog();
      prog_w[0] = mkw(6'h23, 5'd1, d); prog_o[0] = 6'h23; prog_f[0] = 3'b001;
      prog_w[1] = w1;                  prog_o[1] = w1[31:26]; prog_f[1] = f1;
      prog_w[2] = mkw(6'h0D, 5'd4, 5'd4); prog_o[2] = 6'h0D; prog_f[2] = 3'b000;
      do_reset();
   endtask

   task automatic t_reset();
      clear_prog();
      prog_w[0] = 32'hDEAD_BEEF; prog_o[0] = 6'h2A; prog_f[0] = 3'b111;
      do_reset();
      chk(imem_addr == 13'h1000, "R1", "reset address", 32'(imem_addr), 32'h1000);
      chk(de_word == 0 && de_opc == 0, "R1", "reset de word/opc", de_word, 0);
      chk({de_is_load, de_use_rs, de_use_rt} == 3'b000, "R1", "reset flags",
          32'({de_is_load, de_use_rs, de_use_rt}), 0);
      chk(stall == 1'b0, "R1", "reset stall", 32'(stall), 0);
   endtask

   task automatic t_dep_rs();
      load_pair(5'd5, mkw(6'h21, 5'd5, 5'd7), 3'b010);
      step(2);
      chk(stall == 1'b1, "R5", "rs dependence stalls", 32'(stall), 1);
      chk(imem_addr == 13'h1008, "R2", "address before stall", 32'(imem_addr), 32'h1008);
      step(1);
      chk(de_word == 0 && de_opc == 0, "R8", "bubble word/opc", de_word, 0);
      chk({de_is_load, de_use_rs, de_use_rt} == 3'b000, "R8", "bubble flags",
          32'({de_is_load, de_use_rs, de_use_rt}), 0);
      chk(de_pc == 12'h004, "R8", "bubble pc", 32'(de_pc), 32'h4);
      chk(stall == 1'b0, "R10", "stall one cycle", 32'(stall), 0);
      chk(imem_addr == 13'h1008, "R9", "address held", 32'(imem_addr), 32'h1008);
      step(1);
      chk(de_word == mkw(6'h21, 5'd5, 5'd7), "R9", "held instr enters execute",
          de_word, mkw(6'h21, 5'd5, 5'd7));
      chk(de_pc == 12'h004, "R9", "held instr pc", 32'(de_pc), 32'h4);
      chk(imem_addr == 13'h100C, "R2", "fetch resumes", 32'(imem_addr), 32'h100C);
   endtask

   task automatic t_independent();
      load_pair(5'd5, mkw(6'h21, 5'd6, 5'd7), 3'b110);
      step(2);
      chk(stall == 1'b0, "R5", "independent no stall", 32'(stall), 0);
      chk(de_word == mkw(6'h23, 5'd1, 5'd5) && de_opc == 6'h23 && de_is_load,
          "R3", "load reaches execute", de_word, mkw(6'h23, 5'd1, 5'd5));
      chk(de_pc == 12'h000, "R3", "load pc", 32'(de_pc), 0);
      step(1);
      chk(de_word == mkw(6'h21, 5'd6, 5'd7) && de_opc == 6'h21, "R3", "next instr",
          de_word, mkw(6'h21, 5'd6, 5'd7));
      chk(de_pc == 12'h004 && de_use_rs && de_use_rt && !de_is_load, "R3", "next pc/flags",
          32'({de_pc, de_is_load, de_use_rs, de_use_rt}), 32'({12'h004, 3'b011}));
   endtask

   task automatic t_zero();
      load_pair(5'd0, mkw(6'h21, 5'd0, 5'd0), 3'b110);
      step(2);
      chk(stall == 1'b0, "R7", "zero dest no stall", 32'(stall), 0);
      step(1);
      chk(de_pc == 12'h004, "R7", "no bubble inserted", 32'(de_pc), 32'h4);
   endtask

   task automatic t_rt_only();
      load_pair(5'd9, mkw(6'h2B, 5'd9, 5'd3), 3'b100);
      step(2);
      chk(stall == 1'b0, "R6", "rs match unused no stall", 32'(stall), 0);
      load_pair(5'd9, mkw(6'h2B, 5'd2, 5'd9), 3'b100);
      step(2);
      chk(stall == 1'b1, "R6", "rt match stalls", 32'(stall), 1);
      step(1);
      chk(stall == 1'b0, "R10", "rt stall one cycle", 32'(stall), 0);
   endtask

   task automatic t_not_load();
      clear_prog();
      prog_w[0] = mkw(6'h21, 5'd1, 5'd5); prog_o[0] = 6'h21; prog_f[0] = 3'b010;
      prog_w[1] = mkw(6'h21, 5'd5, 5'd5); prog_o[1] = 6'h21; prog_f[1] = 3'b110;
      force_val = 5'd5;
      force_en  = 1'b1;
      do_reset();
      step(2);
      chk(stall == 1'b0, "R4", "non-load no stall", 32'(stall), 0);
      step(1);
      chk(de_pc == 12'h004 && de_word == mkw(6'h21, 5'd5, 5'd5), "R4",
          "no bubble for non-load", de_word, mkw(6'h21, 5'd5, 5'd5));
      force_en = 1'b0;
   endtask

   task automatic t_wrap();
      clear_prog();
      do_reset();
      step(1023);
      chk(imem_addr == 13'h1FFC, "R2", "last word", 32'(imem_addr), 32'h1FFC);
      step(1);
      chk(imem_addr == 13'h1000, "R2", "wrap to base", 32'(imem_addr), 32'h1000);
   endtask

   initial begin : watchdog
      #(20 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      clear_prog();
      step(2);
      t_reset();
      t_dep_rs();
      t_independent();
      t_zero();
      t_rt_only();
      t_not_load();
      t_wrap();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule